// File: doc/BRIEF.md
# Self-Synchronizing Payload Scrambler Pair (x^43 + 1)

This block holds a matched transmit scrambler and receive descrambler for packet payload octets, both built on the self-synchronizing generator x^43 + 1. On the transmit side every output bit is the input bit XOR the scrambled bit sent 43 bit-times earlier. On the receive side every recovered bit is the received bit XOR the received bit from 43 bit-times earlier. The receiver therefore locks onto the sender with no alignment step: after 43 payload bits its history holds the same bits as the sender's.

Each lane accepts one octet per clock with a valid strobe and a scramble-enable. Octets that carry overhead are presented with the enable low. They pass through unchanged and leave the 43-bit history as it was, so only payload advances the sequence. Bits inside an octet are processed most significant first, and both lanes use the same order. The result of each accepted octet appears one clock later on a registered output.

Top module: `pls_scrambler_pair`

## Requirements
- R1: With tx_valid and tx_en high, each bit of tx_out_data equals the tx_data bit XOR the scrambled bit produced 43 payload bits earlier. Bits are taken most significant first (bit 7 is the earliest), and one octet gives the same result as 8 serial steps in that order.
- R2: With rx_valid and rx_en high, each bit of rx_out_data equals the rx_data bit XOR the received bit 43 payload bits earlier, in the same most-significant-first order.
- R3: Synchronous active-high reset clears both output valids and both output data registers to zero, and loads both 43-bit histories with all ones. The first payload octet 0x00 after reset therefore scrambles to 0xFF.
- R4: An octet accepted with its valid high produces its result on the lane's output with out_valid high exactly one clock later.
- R5: An octet presented with valid high and enable low appears unchanged on the output one clock later and does not advance the history. The next payload octet is processed as if the bypassed octet had not been there.
- R6: In a cycle with valid low, out_valid goes low on the next clock, out_data keeps its previous value, and the history does not advance.
- R7: When the descrambler is fed the scrambler's output, it returns the original payload from the 44th payload bit onward (stream bit index 43 and later), whatever histories the two lanes held at the start.
- R8: A single inverted bit on the line at stream bit index p causes exactly two errors in the recovered payload, at bit indices p and p+43, and no others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit octet present this cycle |
| tx_en | input | 1 | Transmit octet is payload and gets scrambled |
| tx_data | input | 8 | Transmit octet, bit 7 sent first |
| tx_out_valid | output | 1 | Transmit result valid |
| tx_out_data | output | 8 | Scrambled or passed-through transmit octet |
| rx_valid | input | 1 | Received octet present this cycle |
| rx_en | input | 1 | Received octet is payload and gets descrambled |
| rx_data | input | 8 | Received octet, bit 7 received first |
| rx_out_valid | output | 1 | Receive result valid |
| rx_out_data | output | 8 | Descrambled or passed-through receive octet |

## Verification
Each lane has one register between input and output, so the result of an octet driven before a rising edge is due on the outputs right after that edge. The bench drives inputs on the falling edge and reads the outputs one time unit after the next rising edge, which is exactly one clock later. Checks that depend on history (R5, R6) compare the first payload octet after the bypass or idle cycle against a bit-serial reference model that was not stepped during that cycle. The chained tests (R7, R8) first collect the scrambled stream and then feed it to the receive lane octet by octet, checking each recovered octet in the cycle after it is sent.

// File: rtl/pls_pkg.sv
package pls_pkg;

    localparam int HIST_LEN  = 43;
    localparam int OCTET_W   = 8;

    typedef enum logic {
        FEED_OUTPUT = 1'b0,
        FEED_INPUT  = 1'b1
    } feed_e;

    function automatic logic [HIST_LEN-1:0] hist_seed();
        return {HIST_LEN{1'b1}};
    endfunction

endpackage

// File: rtl/pls_step.sv
module pls_step
    import pls_pkg::*;
#(
    parameter int    LAG  = HIST_LEN,
    parameter int    W    = OCTET_W,
    parameter feed_e FEED = FEED_OUTPUT
) (
    input  logic [LAG-1:0] hist_i,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   dout,
    output logic [LAG-1:0] hist_o
);
    localparam int OLDEST = LAG - 1;

    logic [W:0][LAG-1:0] chain;

    assign chain[0] = hist_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int B = W - 1 - i;
        logic y;
        assign y       = din[B] ^ chain[i][OLDEST];
        assign dout[B] = y;
        if (FEED == FEED_OUTPUT) begin : g_out_fb
            assign chain[i+1] = {chain[i][LAG-2:0], y};
        end else begin : g_in_fb
            assign chain[i+1] = {chain[i][LAG-2:0], din[B]};
        end
    end

    assign hist_o = chain[W];

endmodule

// File: rtl/pls_lane.sv
module pls_lane
    import pls_pkg::*;
#(
    parameter int    LAG  = HIST_LEN,
    parameter int    W    = OCTET_W,
    parameter feed_e FEED = FEED_OUTPUT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_en,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [LAG-1:0] hist_q;
    logic [LAG-1:0] hist_next;
    logic [W-1:0]   step_data;

    pls_step #(.LAG(LAG), .W(W), .FEED(FEED)) u_step (
        .hist_i (hist_q),
        .din    (in_data),
        .dout   (step_data),
        .hist_o (hist_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q    <= hist_seed();
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_en ? step_data : in_data;
                if (in_en) begin
                    hist_q <= hist_next;
                end
            end
        end
    end

endmodule

// File: rtl/pls_scrambler_pair.sv
module pls_scrambler_pair
    import pls_pkg::*;
#(
    parameter int LAG = HIST_LEN,
    parameter int W   = OCTET_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_valid,
    input  logic         tx_en,
    input  logic [W-1:0] tx_data,
    output logic         tx_out_valid,
    output logic [W-1:0] tx_out_data,
    input  logic         rx_valid,
    input  logic         rx_en,
    input  logic [W-1:0] rx_data,
    output logic         rx_out_valid,
    output logic [W-1:0] rx_out_data
);

    pls_lane #(.LAG(LAG), .W(W), .FEED(FEED_OUTPUT)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (tx_valid),
        .in_en     (tx_en),
        .in_data   (tx_data),
        .out_valid (tx_out_valid),
        .out_data  (tx_out_data)
    );

    pls_lane #(.LAG(LAG), .W(W), .FEED(FEED_INPUT)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rx_valid),
        .in_en     (rx_en),
        .in_data   (rx_data),
        .out_valid (rx_out_valid),
        .out_data  (rx_out_data)
    );

endmodule

// File: rtl/pls_checker.sv
module pls_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tx_valid,
    input logic         tx_en,
    input logic [W-1:0] tx_data,
    input logic         tx_out_valid,
    input logic [W-1:0] tx_out_data,
    input logic         rx_valid,
    input logic         rx_en,
    input logic [W-1:0] rx_data,
    input logic         rx_out_valid,
    input logic [W-1:0] rx_out_data
);

    assert_reset_clears_R3: assert property (@(posedge clk)
        rst |=> (!tx_out_valid && !rx_out_valid && tx_out_data == '0 && rx_out_data == '0));

    assert_tx_latency_R4: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> tx_out_valid);

    assert_rx_latency_R4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> rx_out_valid);

    assert_tx_bypass_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_en) |=> (tx_out_data == $past(tx_data)));

    assert_rx_bypass_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_en) |=> (rx_out_data == $past(rx_data)));

    assert_tx_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |=> (!tx_out_valid && $stable(tx_out_data)));

    assert_rx_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> (!rx_out_valid && $stable(rx_out_data)));

endmodule

bind pls_scrambler_pair pls_checker #(.W(W)) u_pls_checker (
    .clk          (clk),
    .rst          (rst),
    .tx_valid     (tx_valid),
    .tx_en        (tx_en),
    .tx_data      (tx_data),
    .tx_out_valid (tx_out_valid),
    .tx_out_data  (tx_out_data),
    .rx_valid     (rx_valid),
    .rx_en        (rx_en),
    .rx_data      (rx_data),
    .rx_out_valid (rx_out_valid),
    .rx_out_data  (rx_out_data)
);

// File: tb/tb_pls_scrambler_pair.sv
`timescale 1ns/1ps
module tb_pls_scrambler_pair;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_valid = 1'b0, tx_en = 1'b0;
    logic [7:0] tx_data = '0;
    logic       rx_valid = 1'b0, rx_en = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_out_valid, rx_out_valid;
    logic [7:0] tx_out_data, rx_out_data;

    int n_tests = 0;
    int n_fail  = 0;

    logic [42:0] ref_tx;
    logic [42:0] ref_rx;

    always #(CLK_PERIOD/2) clk = ~clk;

    pls_scrambler_pair dut (
        .clk(clk), .rst(rst),
        .tx_valid(tx_valid), .tx_en(tx_en), .tx_data(tx_data),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .rx_valid(rx_valid), .rx_en(rx_en), .rx_data(rx_data),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic ref_tx_byte(input logic [7:0] d, output logic [7:0] o);
        for (int j = 7; j >= 0; j--) begin
            logic b;
            b = d[j] ^ ref_tx[42];
            o[j] = b;
            ref_tx = {ref_tx[41:0], b};
        end
    endtask

    task automatic ref_rx_byte(input logic [7:0] d, output logic [7:0] o);
        for (int j = 7; j >= 0; j--) begin
            o[j] = d[j] ^ ref_rx[42];
            ref_rx = {ref_rx[41:0], d[j]};
        end
    endtask

    task automatic step(input logic tv, input logic te, input logic [7:0] td,
                        input logic rv, input logic re, input logic [7:0] rd);
        @(negedge clk);
        tx_valid = tv; tx_en = te; tx_data = td;
        rx_valid = rv; rx_en = re; rx_data = rd;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tx_valid = 1'b0; rx_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        ref_tx = '1;
        ref_rx = '1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R3 tx_out_valid", {7'd0, tx_out_valid}, 8'h00);
        chk("R3 rx_out_valid", {7'd0, rx_out_valid}, 8'h00);
        chk("R3 tx_out_data", tx_out_data, 8'h00);
        chk("R3 rx_out_data", rx_out_data, 8'h00);
        step(1, 1, 8'h00, 1, 1, 8'h00);
        chk("R3 first tx octet", tx_out_data, 8'hFF);
        chk("R3 first rx octet", rx_out_data, 8'hFF);
        chk("R4 tx_out_valid", {7'd0, tx_out_valid}, 8'h01);
        chk("R4 rx_out_valid", {7'd0, rx_out_valid}, 8'h01);
    endtask

    task automatic t_serial_ref();
        logic [7:0] d, et, er;
        do_reset();
        for (int k = 0; k < 24; k++) begin
            case (k % 4)
                0: d = 8'h00;
                1: d = 8'hFF;
                2: d = 8'(k * 37 + 5);
                default: d = 8'($urandom);
            endcase
            ref_tx_byte(d, et);
            ref_rx_byte(d ^ 8'h5A, er);
            step(1, 1, d, 1, 1, d ^ 8'h5A);
            chk("R1 tx vs serial model", tx_out_data, et);
            chk("R2 rx vs serial model", rx_out_data, er);
        end
    endtask

    task automatic t_bypass();
        logic [7:0] et, er;
        do_reset();
        ref_tx_byte(8'h3C, et); ref_rx_byte(8'h3C, er);
        step(1, 1, 8'h3C, 1, 1, 8'h3C);
        step(1, 0, 8'hA5, 1, 0, 8'h96);
        chk("R5 tx bypass passes data", tx_out_data, 8'hA5);
        chk("R5 rx bypass passes data", rx_out_data, 8'h96);
        for (int k = 0; k < 6; k++) begin
            ref_tx_byte(8'(k + 8'h71), et); ref_rx_byte(8'(k + 8'h19), er);
            step(1, 1, 8'(k + 8'h71), 1, 1, 8'(k + 8'h19));
            chk("R5 tx history not advanced", tx_out_data, et);
            chk("R5 rx history not advanced", rx_out_data, er);
        end
    endtask

    task automatic t_idle();
        logic [7:0] et, er;
        do_reset();
        ref_tx_byte(8'hC3, et); ref_rx_byte(8'h42, er);
        step(1, 1, 8'hC3, 1, 1, 8'h42);
        step(0, 1, 8'h11, 0, 1, 8'h22);
        chk("R6 tx idle valid low", {7'd0, tx_out_valid}, 8'h00);
        chk("R6 rx idle valid low", {7'd0, rx_out_valid}, 8'h00);
        chk("R6 tx idle data held", tx_out_data, et);
        chk("R6 rx idle data held", rx_out_data, er);
        for (int k = 0; k < 6; k++) begin
            ref_tx_byte(8'(k * 3), et); ref_rx_byte(8'(k * 5), er);
            step(1, 1, 8'(k * 3), 1, 1, 8'(k * 5));
            chk("R6 tx history kept", tx_out_data, et);
            chk("R6 rx history kept", rx_out_data, er);
        end
    endtask

    task automatic t_sync();
        logic [7:0] orig [NB];
        logic [7:0] line [NB];
        do_reset();
        for (int k = 0; k < 5; k++) step(1, 1, 8'($urandom), 1, 1, 8'($urandom));
        for (int k = 0; k < NB; k++) begin
            orig[k] = 8'($urandom);
            step(1, 1, orig[k], 0, 1, 8'h00);
            line[k] = tx_out_data;
        end
        for (int k = 0; k < NB; k++) begin
            step(0, 1, 8'h00, 1, 1, line[k]);
            if (k == 5)
                chk("R7 recovery from bit 43", rx_out_data & 8'h1F, orig[k] & 8'h1F);
            else if (k > 5)
                chk("R7 recovered payload", rx_out_data, orig[k]);
        end
    endtask

    task automatic t_err_mult();
        logic [7:0] orig [NB];
        logic [7:0] line [NB];
        logic [8*NB-1:0] emask;
        int p;
        p = 10;
        emask = '0;
        emask[p] = 1'b1;
        emask[p + 43] = 1'b1;
        do_reset();
        for (int k = 0; k < NB; k++) begin
            orig[k] = 8'(k * 29 + 3);
            step(1, 1, orig[k], 0, 1, 8'h00);
            line[k] = tx_out_data;
        end
        line[p / 8][7 - (p % 8)] = ~line[p / 8][7 - (p % 8)];
        for (int k = 0; k < NB; k++) begin
            logic [7:0] em;
            for (int j = 0; j < 8; j++) em[7 - j] = emask[8 * k + j];
            step(0, 1, 8'h00, 1, 1, line[k]);
            chk("R8 error doubled 43 bits apart", rx_out_data, orig[k] ^ em);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_serial_ref();
        t_bypass();
        t_idle();
        t_sync();
        t_err_mult();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule